// File: doc/BRIEF.md
# Dual-Clock Decimal Up/Down Counter

This block holds one decimal digit (0 to 9) in four bits and moves it by one step on each rising transition of either of two count inputs. A rising transition on the up input adds one and a rising transition on the down input subtracts one. Which input moved is the only thing that sets the direction. Both count inputs come from outside the system clock domain. Each passes through a synchroniser before its rising transition is detected on the system clock. Both inputs idle high.

A synchronous clear (active high) and a parallel load (active low, with four preset bits) can force the digit. Two active-low terminal outputs report the digit's limits. The up terminal output pulses low while the digit sits at nine and the up input is low. The down terminal output pulses low while the digit sits at zero and the down input is low. These pulses have the same shape as the count inputs. The up and down terminal outputs of one stage can therefore drive the up and down count inputs of the next stage, and so build a multi-digit counter.

A digit that is loaded with 10 to 15 returns to the decimal range along a fixed path.

Top module: `bcd_updown_counter`

## Requirements
- R1: After reset, count is 0, termUpN is 1 and termDnN is 1.
- R2: A rising transition on upCnt adds one to count. With two synchroniser stages, the new value appears after the third rising system-clock edge that follows the transition.
- R3: A rising transition on dnCnt subtracts one from count.
- R4: Counting up from 9 gives 0, and counting down from 0 gives 9.
- R5: Counting up from a non-decimal value follows 10→11→6, 12→13→4 and 14→15→2.
- R6: Counting down from a non-decimal value steps down by one, for example 15→14→13→12→11→10→9.
- R7: When clearIn is 1 at a clock edge, count becomes 0. Clear overrides the load and any count transition.
- R8: When loadN is 0 and clearIn is 0 at a clock edge, count takes presetVal (bit 0 is the least significant bit). Load overrides any count transition.
- R9: termUpN is 0 only while count bit 0 and count bit 3 are both 1 and the synchronised upCnt is low. Otherwise it is 1.
- R10: termDnN is 0 only while count is 0 and the synchronised dnCnt is low. Otherwise it is 1.
- R11: If rising transitions on upCnt and dnCnt are detected in the same cycle, count does not change.
- R12: Two stages form a two-digit counter when the low stage's termUpN drives the high stage's upCnt and the low stage's termDnN drives the high stage's dnCnt. The pair then counts 00 to 99 in both directions and wraps between 99 and 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| upCnt | input | 1 | Up count input, idles high, acts on its rising transition |
| dnCnt | input | 1 | Down count input, idles high, acts on its rising transition |
| clearIn | input | 1 | Synchronous clear, active high |
| loadN | input | 1 | Synchronous parallel load, active low |
| presetVal | input | 4 | Value taken in on a load |
| count | output | 4 | Current digit |
| termUpN | output | 1 | Overflow pulse, active low |
| termDnN | output | 1 | Underflow pulse, active low |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an up transition and a down transition. The bench drives both inputs low, then releases them on the same cycle so that both synchronisers report the rise together; the digit must not move. The second pair is a count transition and a clear or load. The bench pulses a count input while clear or load is held; the digit must stay at zero or at the preset value, and the checker confirms that clear always wins over load.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

  localparam int DIGIT_W    = 4;
  localparam int DIGIT_LAST = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // strobes from control to datapath, at most one of ld/inc/dec besides clr
  typedef struct packed {
    logic clr;
    logic ld;
    logic inc;
    logic dec;
  } ctrStrobe_t;

  // step up; non-decimal values fold back into range along fixed paths
  function automatic digit_t stepUp(input digit_t v);
    digit_t r;
    case (v)
      digit_t'(DIGIT_LAST): r = '0;
      4'd10: r = 4'd11;
      4'd11: r = 4'd6;
      4'd12: r = 4'd13;
      4'd13: r = 4'd4;
      4'd14: r = 4'd15;
      4'd15: r = 4'd2;
      default: r = v + digit_t'(1);
    endcase
    return r;
  endfunction

  // step down; zero wraps to the last decimal value
  function automatic digit_t stepDown(input digit_t v);
    digit_t r;
    if (v == '0) r = digit_t'(DIGIT_LAST);
    else         r = v - digit_t'(1);
    return r;
  endfunction

endpackage

// File: rtl/bcd_ctr_sync.sv
module bcd_ctr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic syncLvl,
  output logic prevLvl
);

  localparam int CHAIN_LEN = STAGES + 1;

  logic [CHAIN_LEN-1:0] chain;

  // idle level is high, so reset fills the chain with ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[CHAIN_LEN-2:0], din};
  end

  assign syncLvl = chain[STAGES-1];
  assign prevLvl = chain[STAGES];

endmodule

// File: rtl/bcd_ctr_ctrl.sv
module bcd_ctr_ctrl
  import bcd_ctr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       upCnt,
  input  logic       dnCnt,
  input  logic       clearIn,
  input  logic       loadN,
  output ctrStrobe_t strb,
  output logic       upLevel,
  output logic       dnLevel
);

  localparam int NUM_CH = 2;
  localparam int CH_UP  = 0;
  localparam int CH_DN  = 1;

  logic [NUM_CH-1:0] rawIn;
  logic [NUM_CH-1:0] syncLvl;
  logic [NUM_CH-1:0] prevLvl;
  logic [NUM_CH-1:0] riseSeen;

  assign rawIn[CH_UP] = upCnt;
  assign rawIn[CH_DN] = dnCnt;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    bcd_ctr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rstN   (rstN),
      .din    (rawIn[ch]),
      .syncLvl(syncLvl[ch]),
      .prevLvl(prevLvl[ch])
    );
    assign riseSeen[ch] = syncLvl[ch] & ~prevLvl[ch];
  end

  logic forceActive;
  logic soleUp;
  logic soleDn;

  assign forceActive = clearIn | ~loadN;
  assign soleUp      = riseSeen[CH_UP] & ~riseSeen[CH_DN];
  assign soleDn      = riseSeen[CH_DN] & ~riseSeen[CH_UP];

  always_comb begin
    strb.clr = clearIn;
    strb.ld  = ~clearIn & ~loadN;
    strb.inc = ~forceActive & soleUp;
    strb.dec = ~forceActive & soleDn;
  end

  // delayed level: changes on the same edge as the count register
  assign upLevel = prevLvl[CH_UP];
  assign dnLevel = prevLvl[CH_DN];

endmodule

// File: rtl/bcd_ctr_data.sv
module bcd_ctr_data
  import bcd_ctr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrStrobe_t strb,
  input  digit_t     presetVal,
  input  logic       upLevel,
  input  logic       dnLevel,
  output digit_t     count,
  output logic       termUpN,
  output logic       termDnN
);

  digit_t countQ;
  digit_t countD;

  always_comb begin
    countD = countQ;
    if (strb.clr)      countD = '0;
    else if (strb.ld)  countD = presetVal;
    else if (strb.inc) countD = stepUp(countQ);
    else if (strb.dec) countD = stepDown(countQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countD;
  end

  assign count   = countQ;
  assign termUpN = ~(countQ[0] & countQ[DIGIT_W-1] & ~upLevel);
  assign termDnN = ~((countQ == '0) & ~dnLevel);

endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_ctr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         upCnt,
  input  logic         dnCnt,
  input  logic         clearIn,
  input  logic         loadN,
  input  logic [3:0]   presetVal,
  output logic [3:0]   count,
  output logic         termUpN,
  output logic         termDnN
);

  ctrStrobe_t strb;
  logic       upLevel;
  logic       dnLevel;

  bcd_ctr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .upCnt  (upCnt),
    .dnCnt  (dnCnt),
    .clearIn(clearIn),
    .loadN  (loadN),
    .strb   (strb),
    .upLevel(upLevel),
    .dnLevel(dnLevel)
  );

  bcd_ctr_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .presetVal(presetVal),
    .upLevel  (upLevel),
    .dnLevel  (dnLevel),
    .count    (count),
    .termUpN  (termUpN),
    .termDnN  (termDnN)
  );

endmodule

// File: rtl/bcd_ctr_checker.sv
module bcd_ctr_checker
  import bcd_ctr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       clearIn,
  input logic       loadN,
  input logic [3:0] presetVal,
  input logic [3:0] count,
  input logic       termUpN,
  input logic       termDnN,
  input ctrStrobe_t strb
);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (count == 4'd0));

  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clearIn && !loadN) |=> (count == $past(presetVal)));

  p_in_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (count <= 4'd9 && !clearIn && loadN) |=> (count <= 4'd9));

  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && count < 4'd9) |=> (count == $past(count) + 4'd1));

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && count != 4'd0) |=> (count == $past(count) - 4'd1));

  p_no_dual_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.inc && strb.dec));

  p_term_up_r9: assert property (@(posedge clk) disable iff (!rstN)
    !termUpN |-> (count[0] && count[3]));

  p_term_dn_r10: assert property (@(posedge clk) disable iff (!rstN)
    !termDnN |-> (count == 4'd0));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |-> !strb.ld);

endmodule

bind bcd_updown_counter bcd_ctr_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clearIn  (clearIn),
  .loadN    (loadN),
  .presetVal(presetVal),
  .count    (count),
  .termUpN  (termUpN),
  .termDnN  (termDnN),
  .strb     (strb)
);

// File: tb/bcd_updown_counter_bench.sv
module bcd_updown_counter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       upCnt = 1'b1;
  logic       dnCnt = 1'b1;
  logic       clearIn = 1'b0;
  logic       loadN = 1'b1;
  logic [3:0] presetVal = 4'd0;
  logic [3:0] count;
  logic       termUpN;
  logic       termDnN;

  logic [3:0] hiCount;
  logic       hiTermUpN;
  logic       hiTermDnN;
  logic       hiLoadN = 1'b1;
  logic [3:0] hiPreset = 4'd0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bcd_updown_counter u_bcd_updown_counter (
    .clk(clk), .rstN(rstN), .upCnt(upCnt), .dnCnt(dnCnt),
    .clearIn(clearIn), .loadN(loadN), .presetVal(presetVal),
    .count(count), .termUpN(termUpN), .termDnN(termDnN)
  );

  // second digit fed by the first digit's terminal outputs
  bcd_updown_counter u_hiDigit (
    .clk(clk), .rstN(rstN), .upCnt(termUpN), .dnCnt(termDnN),
    .clearIn(clearIn), .loadN(hiLoadN), .presetVal(hiPreset),
    .count(hiCount), .termUpN(hiTermUpN), .termDnN(hiTermDnN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic pulseUp();
    @(negedge clk) upCnt = 1'b0;
    repeat (4) @(negedge clk);
    upCnt = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseDn();
    @(negedge clk) dnCnt = 1'b0;
    repeat (4) @(negedge clk);
    dnCnt = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic loadDigit(input logic [3:0] v);
    @(negedge clk);
    presetVal = v;
    loadN = 1'b0;
    @(negedge clk);
    loadN = 1'b1;
    check(count == v, "R8 load", count, v);
  endtask

  task automatic testReset();
    check(count == 4'd0, "R1 count", count, 0);
    check(termUpN == 1'b1, "R1 termUpN", termUpN, 1);
    check(termDnN == 1'b1, "R1 termDnN", termDnN, 1);
  endtask

  task automatic testUpLatency();
    loadDigit(4'd3);
    @(negedge clk) upCnt = 1'b0;
    repeat (4) @(negedge clk);
    upCnt = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(count == 4'd3, "R2 before third edge", count, 3);
    @(negedge clk);
    check(count == 4'd4, "R2 after third edge", count, 4);
    repeat (6) @(negedge clk);
    pulseUp();
    check(count == 4'd5, "R2 second step", count, 5);
  endtask

  task automatic testDown();
    loadDigit(4'd7);
    pulseDn();
    check(count == 4'd6, "R3 step down", count, 6);
    pulseDn();
    check(count == 4'd5, "R3 step down again", count, 5);
  endtask

  task automatic testWrap();
    loadDigit(4'd9);
    pulseUp();
    check(count == 4'd0, "R4 up wrap", count, 0);
    pulseDn();
    check(count == 4'd9, "R4 down wrap", count, 9);
  endtask

  task automatic testInvalidUp();
    loadDigit(4'd10);
    pulseUp(); check(count == 4'd11, "R5 10 up", count, 11);
    pulseUp(); check(count == 4'd6,  "R5 11 up", count, 6);
    loadDigit(4'd12);
    pulseUp(); check(count == 4'd13, "R5 12 up", count, 13);
    pulseUp(); check(count == 4'd4,  "R5 13 up", count, 4);
    loadDigit(4'd14);
    pulseUp(); check(count == 4'd15, "R5 14 up", count, 15);
    pulseUp(); check(count == 4'd2,  "R5 15 up", count, 2);
  endtask

  task automatic testInvalidDown();
    loadDigit(4'd15);
    for (int e = 14; e >= 9; e--) begin
      pulseDn();
      check(count == 4'(e), "R6 invalid down", count, e);
    end
  endtask

  task automatic testClear();
    loadDigit(4'd5);
    @(negedge clk);
    clearIn = 1'b1;
    loadN = 1'b0;
    presetVal = 4'd7;
    @(negedge clk);
    check(count == 4'd0, "R7 clear over load", count, 0);
    pulseUp();
    check(count == 4'd0, "R7 clear over count", count, 0);
    clearIn = 1'b0;
    @(negedge clk);
    check(count == 4'd7, "R8 load after clear", count, 7);
    pulseDn();
    check(count == 4'd7, "R8 load over count", count, 7);
    loadN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testTermUp();
    loadDigit(4'd9);
    check(termUpN == 1'b1, "R9 idle at nine", termUpN, 1);
    @(negedge clk) upCnt = 1'b0;
    repeat (4) @(negedge clk);
    check(termUpN == 1'b0, "R9 low at nine", termUpN, 0);
    check(termDnN == 1'b1, "R10 quiet at nine", termDnN, 1);
    upCnt = 1'b1;
    repeat (8) @(negedge clk);
    check(termUpN == 1'b1, "R9 released", termUpN, 1);
    loadDigit(4'd5);
    @(negedge clk) upCnt = 1'b0;
    repeat (4) @(negedge clk);
    check(termUpN == 1'b1, "R9 quiet at five", termUpN, 1);
    upCnt = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic testTermDn();
    loadDigit(4'd0);
    @(negedge clk) dnCnt = 1'b0;
    repeat (4) @(negedge clk);
    check(termDnN == 1'b0, "R10 low at zero", termDnN, 0);
    dnCnt = 1'b1;
    repeat (8) @(negedge clk);
    check(termDnN == 1'b1, "R10 released", termDnN, 1);
    loadDigit(4'd2);
    @(negedge clk) dnCnt = 1'b0;
    repeat (4) @(negedge clk);
    check(termDnN == 1'b1, "R10 quiet at two", termDnN, 1);
    dnCnt = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic testBoth();
    loadDigit(4'd4);
    @(negedge clk);
    upCnt = 1'b0;
    dnCnt = 1'b0;
    repeat (4) @(negedge clk);
    upCnt = 1'b1;
    dnCnt = 1'b1;
    repeat (8) @(negedge clk);
    check(count == 4'd4, "R11 simultaneous", count, 4);
  endtask

  task automatic testCascade();
    int model;
    @(negedge clk) clearIn = 1'b1;
    @(negedge clk) clearIn = 1'b0;
    repeat (4) @(negedge clk);
    model = 0;
    check({hiCount, count} == 8'h00, "R12 start", {hiCount, count}, 0);
    for (int i = 0; i < 100; i++) begin
      pulseUp();
      model = (model + 1) % 100;
      repeat (4) @(negedge clk);
      check(hiCount == 4'(model / 10) && count == 4'(model % 10), "R12 up",
            hiCount * 10 + count, model);
    end
    for (int i = 0; i < 100; i++) begin
      pulseDn();
      model = (model + 99) % 100;
      repeat (4) @(negedge clk);
      check(hiCount == 4'(model / 10) && count == 4'(model % 10), "R12 down",
            hiCount * 10 + count, model);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUpLatency();
    testDown();
    testWrap();
    testInvalidUp();
    testInvalidDown();
    testClear();
    testTermUp();
    testTermDn();
    testBoth();
    testCascade();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      report();
      $finish;
    end
  end

endmodule